// File: doc/BRIEF.md
# Instruction-Boundary Sequencer

This block is the outer loop of a simple processor. It decides what happens between two instructions: whether the machine is running at all, whether a pending soft reset should send the program counter back to zero, whether an external interrupt should be taken, or whether the next instruction may be fetched. The fetch and execute machinery is not part of the block. It is represented by a handshake. The sequencer pulses `fetch_o` to launch an instruction. The execution engine raises `done_i` together with the next program counter when that instruction has finished.

Start, reset and interrupt inputs never cut an instruction short. A start request is honoured only while the machine is halted. A reset request is remembered until the next boundary. An interrupt request is weighed against the enable flag only at a boundary. Interrupt entry happens in one step: it saves the program counter and the source code, pulses the acknowledge, clears the enable flag and loads the vector address. A step counter reports how many cycles the current instruction has used.

Top module: `boundary_sequencer`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it is released, `run_o`, `pc_o`, `step_o`, `fetch_o`, `rf_clr_o`, `iack_o` and `ie_o` are all zero.
- R2: When `strt_i` is high while the machine is halted, then after the next clock edge `run_o` is 1, `pc_o` is 0 and `rf_clr_o` is high for exactly one cycle. When `strt_i` is high while the machine is running, it changes neither `pc_o` nor `run_o`, and it raises no `rf_clr_o`.
- R3: While halted, the block issues no `fetch_o` and no `iack_o`, even when `ireq_i` and `ie_o` are both high.
- R4: At a boundary with no pending reset and no enabled interrupt, `fetch_o` is high for one cycle after the next edge. `step_o` is 0 in that cycle and rises by one each further cycle of the instruction. When `done_i` is high, the next edge loads `pc_next_i` into `pc_o` and returns `step_o` to 0.
- R5: A one-cycle pulse on `rst_req_i` is held as pending and does not disturb an instruction in progress. At the next boundary it sets `pc_o` and `step_o` to 0 with no fetch in that cycle. The boundary after that is evaluated normally.
- R6: At a boundary with `ireq_i` and `ie_o` both high and no pending reset, after the next edge `ipc_o` holds the old `pc_o`, `ii_o` holds `isrc_i`, `pc_o` equals the vector address (default 0x0100), `ie_o` is 0 and `iack_o` is 1.
- R7: `iack_o` is high for exactly one cycle. The following boundary fetches from the vector address.
- R8: When `ie_o` is 0, `ireq_i` is ignored. The fetch goes ahead and `iack_o` stays low.
- R9: `ie_o` becomes 1 only on the edge after a pulse on `ie_set_i`. After an interrupt entry it stays 0 until `ie_set_i` is pulsed again.
- R10: At a single boundary, a pending reset is served before an enabled interrupt, and an enabled interrupt is served before a fetch.
- R11: An interrupt request that arrives during an instruction is taken only after `done_i` has ended that instruction.
- R12: With the default saturating step counter (3 bits), `step_o` stops at 7 during a long instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| strt_i | input | 1 | Start request; honoured while halted |
| rst_req_i | input | 1 | Soft reset request; held until the next boundary |
| ireq_i | input | 1 | External interrupt request level |
| isrc_i | input | SRC_W (4) | Interrupt source code, captured on entry |
| ie_set_i | input | 1 | Enable-interrupt pulse |
| done_i | input | 1 | Current instruction has completed |
| pc_next_i | input | ADDR_W (16) | Program counter after the completing instruction |
| run_o | output | 1 | Machine is running |
| pc_o | output | ADDR_W (16) | Program counter |
| step_o | output | STEP_W (3) | Cycles used by the current instruction |
| fetch_o | output | 1 | One-cycle launch of the next instruction |
| rf_clr_o | output | 1 | One-cycle clear of the general registers |
| iack_o | output | 1 | Interrupt acknowledge pulse |
| ie_o | output | 1 | Interrupt enable flag |
| ipc_o | output | ADDR_W (16) | Program counter saved on interrupt entry |
| ii_o | output | SRC_W (4) | Source code saved on interrupt entry |

## Verification
Every result of this block is registered and appears one edge after the condition that causes it. A start shows on `run_o`, `pc_o` and `rf_clr_o` one edge after `strt_i`. A boundary decision (fetch pulse, reset or interrupt entry) shows one edge after the edge that completed the instruction with `done_i`. The acknowledge falls on the edge after that, and a reset followed by an entry takes one extra edge each. The bench drives inputs and samples outputs 1 ns after each rising edge. It advances exactly one edge per stimulus step, so each expected value is compared in the cycle where it is due and not a cycle early or late.

// File: rtl/bseq_pkg.sv
package bseq_pkg;

   // Phase of the outer instruction loop
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_BOUND = 2'd1,
      ST_EXEC  = 2'd2
   } seq_state_e;

   // What the arbiter chose for this cycle
   typedef enum logic [1:0] {
      ACT_NONE  = 2'd0,
      ACT_RESET = 2'd1,
      ACT_ENTRY = 2'd2,
      ACT_FETCH = 2'd3
   } bound_act_e;

endpackage

// File: rtl/bseq_arbiter.sv
module bseq_arbiter
   import bseq_pkg::*;
(
   input  logic       at_bound,
   input  logic       rst_pend,
   input  logic       ireq,
   input  logic       ie,
   output bound_act_e act
);

   // Fixed priority: pending reset, then enabled interrupt, then fetch
   always_comb begin
      act = ACT_NONE;
      if (at_bound) begin
         if (rst_pend)
            act = ACT_RESET;
         else if (ireq && ie)
            act = ACT_ENTRY;
         else
            act = ACT_FETCH;
      end
   end

endmodule

// File: rtl/bseq_step_ctr.sv
module bseq_step_ctr #(
   parameter int unsigned STEP_W = 3,
   parameter bit          SAT    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              en,
   output logic [STEP_W-1:0] step
);

   localparam logic [STEP_W-1:0] STEP_MAX = {STEP_W{1'b1}};

   logic [STEP_W-1:0] step_inc;

   generate
      if (SAT) begin : g_sat
         assign step_inc = (step == STEP_MAX) ? step : step + 1'b1;
      end else begin : g_wrap
         assign step_inc = step + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         step <= '0;
      else if (clr)
         step <= '0;
      else if (en)
         step <= step_inc;
   end

endmodule

// File: rtl/bseq_irq_ctx.sv
module bseq_irq_ctx #(
   parameter int unsigned ADDR_W = 16,
   parameter int unsigned SRC_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              take,
   input  logic              ie_set,
   input  logic [ADDR_W-1:0] pc,
   input  logic [SRC_W-1:0]  src,
   output logic              ie,
   output logic              iack,
   output logic [ADDR_W-1:0] ipc,
   output logic [SRC_W-1:0]  ii
);

   // Entry saves context, acknowledges and disables in the same edge
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ie   <= 1'b0;
         iack <= 1'b0;
         ipc  <= '0;
         ii   <= '0;
      end else begin
         iack <= take;
         if (take) begin
            ipc <= pc;
            ii  <= src;
            ie  <= 1'b0;
         end else if (ie_set) begin
            ie  <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/boundary_sequencer.sv
module boundary_sequencer
   import bseq_pkg::*;
#(
   parameter int unsigned ADDR_W   = 16,
   parameter int unsigned SRC_W    = 4,
   parameter int unsigned STEP_W   = 3,
   parameter bit          STEP_SAT = 1'b1,
   parameter int unsigned VEC_ADDR = 256
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              strt_i,
   input  logic              rst_req_i,
   input  logic              ireq_i,
   input  logic [SRC_W-1:0]  isrc_i,
   input  logic              ie_set_i,
   input  logic              done_i,
   input  logic [ADDR_W-1:0] pc_next_i,
   output logic              run_o,
   output logic [ADDR_W-1:0] pc_o,
   output logic [STEP_W-1:0] step_o,
   output logic              fetch_o,
   output logic              rf_clr_o,
   output logic              iack_o,
   output logic              ie_o,
   output logic [ADDR_W-1:0] ipc_o,
   output logic [SRC_W-1:0]  ii_o
);

   localparam logic [ADDR_W-1:0] VEC = VEC_ADDR[ADDR_W-1:0];

   generate
      if (ADDR_W < 2 || ADDR_W > 32) begin : g_bad_addr
         $error("ADDR_W must lie in 2..32");
      end
      if (SRC_W < 1) begin : g_bad_src
         $error("SRC_W must be at least 1");
      end
      if (STEP_W < 1) begin : g_bad_step
         $error("STEP_W must be at least 1");
      end
      if (ADDR_W < 32 && VEC_ADDR >= (32'd1 << ADDR_W)) begin : g_bad_vec
         $error("VEC_ADDR does not fit in ADDR_W bits");
      end
   endgenerate

   seq_state_e        state;
   bound_act_e        act;
   logic              rst_pend;
   logic              rst_pend_clr;
   logic              start_take;
   logic              fetch_q;
   logic              rf_clr_q;
   logic [ADDR_W-1:0] pc_q;
   logic              ie_w;
   logic              step_clr;
   logic              step_en;

   assign start_take   = (state == ST_IDLE) && strt_i;
   assign rst_pend_clr = start_take || (act == ACT_RESET);

   bseq_arbiter u_arb (
      .at_bound (state == ST_BOUND),
      .rst_pend (rst_pend),
      .ireq     (ireq_i),
      .ie       (ie_w),
      .act      (act)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         pc_q     <= '0;
         fetch_q  <= 1'b0;
         rf_clr_q <= 1'b0;
         rst_pend <= 1'b0;
      end else begin
         fetch_q  <= 1'b0;
         rf_clr_q <= 1'b0;
         rst_pend <= (rst_pend && !rst_pend_clr) || rst_req_i;
         case (state)
            ST_IDLE: begin
               if (strt_i) begin
                  state    <= ST_BOUND;
                  pc_q     <= '0;
                  rf_clr_q <= 1'b1;
               end
            end
            ST_BOUND: begin
               case (act)
                  ACT_RESET: pc_q <= '0;
                  ACT_ENTRY: pc_q <= VEC;
                  ACT_FETCH: begin
                     state   <= ST_EXEC;
                     fetch_q <= 1'b1;
                  end
                  default: ;
               endcase
            end
            ST_EXEC: begin
               if (done_i) begin
                  pc_q  <= pc_next_i;
                  state <= ST_BOUND;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign step_clr = (act == ACT_FETCH) || (act == ACT_RESET) ||
                     ((state == ST_EXEC) && done_i);
   assign step_en  = (state == ST_EXEC);

   bseq_step_ctr #(
      .STEP_W (STEP_W),
      .SAT    (STEP_SAT)
   ) u_step (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (step_clr),
      .en    (step_en),
      .step  (step_o)
   );

   bseq_irq_ctx #(
      .ADDR_W (ADDR_W),
      .SRC_W  (SRC_W)
   ) u_ctx (
      .clk    (clk),
      .rst_n  (rst_n),
      .take   (act == ACT_ENTRY),
      .ie_set (ie_set_i),
      .pc     (pc_q),
      .src    (isrc_i),
      .ie     (ie_w),
      .iack   (iack_o),
      .ipc    (ipc_o),
      .ii     (ii_o)
   );

   assign run_o    = (state != ST_IDLE);
   assign pc_o     = pc_q;
   assign fetch_o  = fetch_q;
   assign rf_clr_o = rf_clr_q;
   assign ie_o     = ie_w;

endmodule

// File: rtl/bseq_checker.sv
module bseq_checker #(
   parameter int unsigned ADDR_W   = 16,
   parameter int unsigned STEP_W   = 3,
   parameter int unsigned VEC_ADDR = 256
) (
   input logic              clk,
   input logic              rst_n,
   input logic              run,
   input logic [ADDR_W-1:0] pc,
   input logic [STEP_W-1:0] step,
   input logic              fetch,
   input logic              rf_clr,
   input logic              iack,
   input logic              ie,
   input logic              ie_set,
   input logic [ADDR_W-1:0] ipc
);

   localparam logic [ADDR_W-1:0] VEC = VEC_ADDR[ADDR_W-1:0];

   // R7
   iack_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      iack |=> !iack);

   // R6
   entry_ctx_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(iack) |-> (ipc == $past(pc) && pc == VEC && !ie));

   // R3
   fetch_needs_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fetch |-> run);

   // R10
   fetch_iack_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(fetch && iack));

   // R2
   rf_clr_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rf_clr |-> (run && pc == '0));

   // R4
   fetch_step_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fetch |-> (step == '0));

   // R9
   ie_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ie) |-> $past(ie_set));

endmodule

bind boundary_sequencer bseq_checker #(
   .ADDR_W   (ADDR_W),
   .STEP_W   (STEP_W),
   .VEC_ADDR (VEC_ADDR)
) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .run    (run_o),
   .pc     (pc_o),
   .step   (step_o),
   .fetch  (fetch_o),
   .rf_clr (rf_clr_o),
   .iack   (iack_o),
   .ie     (ie_o),
   .ie_set (ie_set_i),
   .ipc    (ipc_o)
);

// File: tb/boundary_sequencer_tb.sv
`timescale 1ns/1ps
module boundary_sequencer_tb_top;

   localparam logic [15:0] VEC = 16'h0100;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        strt_i, rst_req_i, ireq_i, ie_set_i, done_i;
   logic [3:0]  isrc_i;
   logic [15:0] pc_next_i;
   logic        run_o, fetch_o, rf_clr_o, iack_o, ie_o;
   logic [15:0] pc_o, ipc_o;
   logic [2:0]  step_o;
   logic [3:0]  ii_o;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   boundary_sequencer dut_i (
      .clk (clk), .rst_n (rst_n), .strt_i (strt_i), .rst_req_i (rst_req_i),
      .ireq_i (ireq_i), .isrc_i (isrc_i), .ie_set_i (ie_set_i),
      .done_i (done_i), .pc_next_i (pc_next_i), .run_o (run_o),
      .pc_o (pc_o), .step_o (step_o), .fetch_o (fetch_o),
      .rf_clr_o (rf_clr_o), .iack_o (iack_o), .ie_o (ie_o),
      .ipc_o (ipc_o), .ii_o (ii_o)
   );

   // Boundary scenario: inputs given while the instruction ends, expected result
   typedef struct packed {
      logic        rst;
      logic        irq;
      logic        ies;
      logic [3:0]  src;
      logic [15:0] pcn;
      logic [1:0]  first;   // 0 fetch, 1 reset, 2 entry
      logic        ent;     // an entry happens before the next fetch
      logic [15:0] ipc;
      logic        ie;      // enable flag after the decision edge
   } vec_t;

   localparam int NV = 7;
   localparam vec_t TBL [NV] = '{
      '{1'b0, 1'b1, 1'b0, 4'h3, 16'h0010, 2'd0, 1'b0, 16'h0000, 1'b0},
      '{1'b0, 1'b0, 1'b1, 4'h0, 16'h0020, 2'd0, 1'b0, 16'h0000, 1'b1},
      '{1'b0, 1'b1, 1'b0, 4'h5, 16'h0030, 2'd2, 1'b1, 16'h0030, 1'b0},
      '{1'b0, 1'b1, 1'b0, 4'h6, 16'h0040, 2'd0, 1'b0, 16'h0000, 1'b0},
      '{1'b1, 1'b1, 1'b1, 4'h7, 16'h0050, 2'd1, 1'b1, 16'h0000, 1'b1},
      '{1'b1, 1'b0, 1'b0, 4'h0, 16'h0060, 2'd1, 1'b0, 16'h0000, 1'b0},
      '{1'b0, 1'b1, 1'b1, 4'h9, 16'h0070, 2'd2, 1'b1, 16'h0070, 1'b0}
   };

   task automatic chk(input bit ok, input string req, input logic [31:0] got,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: got %0h expected %0h (t=%0t)", req, got, exp, $time);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
   end

   initial begin
      rst_n = 1'b0; strt_i = 0; rst_req_i = 0; ireq_i = 0; ie_set_i = 0;
      done_i = 0; isrc_i = '0; pc_next_i = '0;
      repeat (3) tick();
      // R1 reset state
      chk({run_o, pc_o, step_o, fetch_o, rf_clr_o, iack_o, ie_o} == '0, "R1",
          {run_o, fetch_o, iack_o, ie_o}, 0);
      rst_n = 1'b1;
      tick();
      chk({run_o, pc_o, fetch_o, iack_o} == '0, "R1 after release", pc_o, 0);

      // R2 start from halt
      strt_i = 1'b1;
      tick();
      strt_i = 1'b0;
      chk(run_o && pc_o == 0 && rf_clr_o, "R2 start", {run_o, rf_clr_o}, 2'b11);
      tick();
      // R4 first fetch, register clear was one cycle
      chk(!rf_clr_o, "R2 clear pulse width", rf_clr_o, 0);
      chk(fetch_o && step_o == 0, "R4 fetch", {fetch_o, step_o}, 4'b1000);
      tick();
      chk(!fetch_o && step_o == 1, "R4 step count", step_o, 1);
      strt_i = 1'b1;
      tick();
      strt_i = 1'b0;
      chk(!rf_clr_o && run_o && pc_o == 0 && step_o == 2, "R2 start ignored",
          {rf_clr_o, step_o}, 2);
      rst_req_i = 1'b1;
      tick();
      rst_req_i = 1'b0;
      // R5 reset request does not abort the running instruction
      chk(step_o == 3 && !fetch_o, "R5 no abort", step_o, 3);
      repeat (6) tick();
      chk(step_o == 7, "R12 saturation", step_o, 7);
      done_i = 1'b1; pc_next_i = 16'h0200;
      tick();
      done_i = 1'b0;
      chk(pc_o == 16'h0200 && step_o == 0, "R4 done loads pc", pc_o, 16'h0200);
      tick();
      chk(pc_o == 0 && !fetch_o && step_o == 0, "R5 reset at boundary", pc_o, 0);
      tick();
      chk(fetch_o && pc_o == 0, "R5 resume fetch", fetch_o, 1);

      // R6 R8 R9 R10 boundary scenarios
      for (int v = 0; v < NV; v++) begin
         int entries;
         bit seen_fetch;
         bit prev_iack;
         logic [15:0] exp_pc;
         entries = 0; seen_fetch = 0; prev_iack = 0;
         rst_req_i = TBL[v].rst; ireq_i = TBL[v].irq; ie_set_i = TBL[v].ies;
         isrc_i = TBL[v].src; done_i = 1'b1; pc_next_i = TBL[v].pcn;
         tick();
         rst_req_i = 1'b0; ie_set_i = 1'b0; done_i = 1'b0;
         for (int k = 0; k < 5 && !seen_fetch; k++) begin
            tick();
            if (k == 0) begin
               exp_pc = (TBL[v].first == 2'd0) ? TBL[v].pcn :
                        (TBL[v].first == 2'd1) ? 16'h0000 : VEC;
               chk(pc_o == exp_pc, "R10 decision pc", pc_o, exp_pc);
               chk(fetch_o == (TBL[v].first == 2'd0), "R8 R10 fetch", fetch_o,
                   TBL[v].first == 2'd0);
               chk(iack_o == (TBL[v].first == 2'd2), "R6 R10 iack", iack_o,
                   TBL[v].first == 2'd2);
               chk(ie_o == TBL[v].ie, "R9 enable", ie_o, TBL[v].ie);
            end
            if (prev_iack)
               chk(!iack_o && fetch_o && pc_o == VEC, "R7 one-cycle ack",
                   {iack_o, fetch_o}, 2'b01);
            if (iack_o) begin
               entries++;
               chk(ipc_o == TBL[v].ipc && ii_o == TBL[v].src && pc_o == VEC && !ie_o,
                   "R6 entry context", {ipc_o, ii_o}, {TBL[v].ipc, TBL[v].src});
               ireq_i = 1'b0;
            end
            prev_iack = iack_o;
            if (fetch_o) begin
               seen_fetch = 1'b1;
               ireq_i = 1'b0;
            end
         end
         chk(entries == int'(TBL[v].ent), "R10 entry count", entries, TBL[v].ent);
         chk(seen_fetch, "R4 fetch reached", seen_fetch, 1);
      end

      // R11 request during an instruction waits for completion
      ie_set_i = 1'b1; ireq_i = 1'b1; isrc_i = 4'hA;
      tick();
      ie_set_i = 1'b0;
      tick();
      tick();
      chk(!iack_o && ie_o && step_o == 3, "R11 held off", {iack_o, step_o}, 3);
      done_i = 1'b1; pc_next_i = 16'h0080;
      tick();
      done_i = 1'b0;
      chk(!iack_o && pc_o == 16'h0080, "R11 boundary reached", pc_o, 16'h0080);
      tick();
      chk(iack_o && ipc_o == 16'h0080 && ii_o == 4'hA, "R11 taken", ipc_o, 16'h0080);
      ireq_i = 1'b0;

      // R3 halted machine ignores an enabled interrupt
      rst_n = 1'b0;
      tick();
      rst_n = 1'b1;
      ie_set_i = 1'b1;
      tick();
      ie_set_i = 1'b0; ireq_i = 1'b1;
      repeat (3) tick();
      chk(ie_o && !iack_o && !fetch_o && !run_o, "R3 halted",
          {ie_o, iack_o, fetch_o, run_o}, 4'b1000);
      ireq_i = 1'b0;

      summary();
   end

endmodule